// File: doc/BRIEF.md
# Enable-Based Rate Selector

This block picks between a full-rate and a half-rate update for a data register without touching the clock net. One clock drives every flip-flop. Inside the block, a toggle flip-flop divides that clock by two and produces a half-rate phase. A rate select input then decides how the output register loads. In full-rate mode it loads on every rising edge. In half-rate mode it loads only on edges where the phase is high.

The choice reaches the register only through its load enable. No gate or multiplexer sits in front of any clock pin. A change of the select input while both the clock and the phase are high therefore cannot produce a runt clock pulse. The select is registered once inside the block, so each change takes effect at a clean edge boundary. The update pattern is the one a clock multiplexer choosing between the clock and its divided copy would give, but without the hazard.

Top module: `rate_enable_select`

## Requirements
- R1: While `rst` is high at a rising edge, the edge clears `dout` and `half_phase` to zero and sets the internal registered rate to full rate.
- R2: After reset is released, `half_phase` inverts on every rising edge, so it reads 1 after the first edge, 0 after the second, and so on.
- R3: When the registered rate is full rate (select value 0), every rising edge loads `din` into `dout`.
- R4: `rate_sel` is sampled at a rising edge, and the sampled value governs the load decision of the following edge, not the edge at which it was sampled.
- R5: When the registered rate is half rate (select value 1), an edge loads `din` only if `half_phase` was 1 just before that edge. Otherwise `dout` holds its value.
- R6: In half-rate mode, `dout` changes at most on every second edge. It is never updated on two consecutive edges while the registered rate stays at 1.
- R7: A change of `rate_sel` in either direction, whether `half_phase` is high or low, neither drops nor adds a load relative to the rules of R3 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for every flip-flop |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 1 | 0 selects full rate, 1 selects half rate |
| din | input | DATA_W | Data to be loaded |
| dout | output | DATA_W | Registered data output |
| half_phase | output | 1 | Divide-by-two phase, for observation |

## Verification
The hardest case is a select change that lands exactly when the divided phase is high. In the multiplexed-clock form this is the glitch case. Here, an off-by-one in the select pipeline would show up as a dropped or extra load on precisely that edge. The stimulus reads `half_phase` at the falling edge and flips `rate_sel` in both directions, once on a high phase and once on a low one. It also changes `din` on every cycle, so that any load on the wrong edge changes the output. A reset in the middle of half-rate operation checks that the phase and the select restart from known values.

// File: rtl/rate_sel_pkg.sv
package rate_sel_pkg;

    // Encoding of the rate select: 0 = full rate, 1 = half rate
    typedef enum logic {
        RATE_FULL = 1'b0,
        RATE_HALF = 1'b1
    } rate_t;

    typedef struct packed {
        logic  phase;
        rate_t rate;
    } ctrl_t;

    function automatic logic load_allowed(rate_t rate, logic phase);
        return (rate == RATE_FULL) || phase;
    endfunction

endpackage

// File: rtl/rs_phase_gen.sv
module rs_phase_gen (
    input  logic clk,
    input  logic rst,
    output logic phase_o
);
    logic phase_d, phase_q;

    always_comb begin
        phase_d = rst ? 1'b0 : ~phase_q;
    end

    always_ff @(posedge clk) begin
        phase_q <= phase_d;
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/rs_sel_stage.sv
module rs_sel_stage
    import rate_sel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_i,
    output rate_t rate_o
);
    rate_t rate_d, rate_q;

    always_comb begin
        if (rst) rate_d = RATE_FULL;
        else     rate_d = rate_t'(sel_i);
    end

    always_ff @(posedge clk) begin
        rate_q <= rate_d;
    end

    assign rate_o = rate_q;
endmodule

// File: rtl/rs_hold_reg.sv
module rs_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (rst)       data_d = '0;
        else if (en_i) data_d = d_i;
    end

    always_ff @(posedge clk) begin
        data_q <= data_d;
    end

    assign q_o = data_q;
endmodule

// File: rtl/rate_enable_select.sv
module rate_enable_select
    import rate_sel_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rate_sel,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              half_phase
);
    ctrl_t ctrl;
    logic  load_en;

    rs_phase_gen u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_o (ctrl.phase)
    );

    rs_sel_stage u_sel (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (rate_sel),
        .rate_o (ctrl.rate)
    );

    // The rate choice reaches the register only through its enable
    always_comb begin
        load_en = load_allowed(ctrl.rate, ctrl.phase);
    end

    rs_hold_reg #(.W(DATA_W)) u_data (
        .clk  (clk),
        .rst  (rst),
        .en_i (load_en),
        .d_i  (din),
        .q_o  (dout)
    );

    assign half_phase = ctrl.phase;
endmodule

// File: rtl/rate_enable_select_chk.sv
module rate_enable_select_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rate_sel,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              half_phase
);
    // Edges since reset release, saturating at 3
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)             age_q <= 2'd0;
        else if (age_q != 3) age_q <= age_q + 2'd1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (dout == '0 && half_phase == 1'b0));

    p_phase_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd1) |-> (half_phase != $past(half_phase)));

    p_full_load_r3: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && !$past(rate_sel, 2)) |-> (dout == $past(din)));

    p_half_load_r5: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && $past(rate_sel, 2) && $past(half_phase))
            |-> (dout == $past(din)));

    p_half_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && $past(rate_sel, 2) && !$past(half_phase))
            |-> $stable(dout));
endmodule

bind rate_enable_select rate_enable_select_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rate_sel   (rate_sel),
    .din        (din),
    .dout       (dout),
    .half_phase (half_phase)
);

// File: tb/rate_enable_select_test.sv
module rate_enable_select_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rate_sel = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         half_phase;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rate_enable_select #(.DATA_W(W)) uut (
        .clk(clk), .rst(rst), .rate_sel(rate_sel),
        .din(din), .dout(dout), .half_phase(half_phase)
    );

    // Behavioural reference model
    int    edges = 0;
    int    exp_dout = 0;
    int    exp_phase = 0;
    int    last_sel = 0;
    string tag = "R1";

    always @(posedge clk) begin
        if (rst) begin
            exp_dout = 0; edges = 0; last_sel = 0; tag = "R1";
        end else begin
            if (last_sel == 0) begin
                exp_dout = int'(din); tag = "R3";
            end else if (edges % 2 == 1) begin
                exp_dout = int'(din); tag = "R5";
            end else begin
                tag = "R6";
            end
            if (int'(rate_sel) != last_sel) tag = {tag, "/R4/R7"};
            last_sel = int'(rate_sel);
            edges++;
        end
        exp_phase = edges % 2;
    end

    task automatic compare();
        checks++;
        if (int'(dout) != exp_dout) begin
            fails++;
            $display("FAIL %s dout actual=%0d expected=%0d t=%0t", tag, dout, exp_dout, $time);
        end
        checks++;
        if (int'(half_phase) != exp_phase) begin
            fails++;
            $display("FAIL %s R2 half_phase actual=%0d expected=%0d t=%0t",
                     tag, half_phase, exp_phase, $time);
        end
    endtask

    always @(negedge clk) compare();

    task automatic run(int n, int sel);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            rate_sel = sel[0];
            din = W'($urandom);
        end
    endtask

    task automatic flip_on_phase(logic want_phase);
        @(negedge clk);
        #1;
        while (half_phase != want_phase) begin
            din = W'($urandom);
            @(negedge clk);
            #1;
        end
        rate_sel = ~rate_sel;
        din = W'($urandom);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        run(20, 0);            // R3 full rate
        run(30, 1);            // R5/R6 half rate
        flip_on_phase(1'b1);   // R7 1 -> 0 at high phase
        run(5, 0);
        flip_on_phase(1'b1);   // 0 -> 1 at high phase
        run(6, 1);
        flip_on_phase(1'b0);   // 1 -> 0 at low phase
        run(5, 0);
        flip_on_phase(1'b0);   // 0 -> 1 at low phase
        run(7, 1);
        for (int k = 0; k < 40; k++) run(1, int'($urandom % 2));  // R4 fast toggling
        @(negedge clk); #1 rst = 1'b1;   // R1 mid-run reset
        run(3, 1);
        @(negedge clk); #1 rst = 1'b0;
        run(20, 1);
        run(10, 0);
        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule